// File: doc/BRIEF.md
# Dual-Issue Reorder Buffer with In-Order Retirement

This block is the in-order retirement window of a two-wide out-of-order core. In each cycle, dispatch may claim up to two ring slots for renamed instructions. Each claimed slot is identified by its index, called a ticket. Functional units return results out of order and use the ticket to pick the slot they fill. Each slot keeps a pending flag until its result arrives. Retirement looks at the two oldest slots every cycle. It retires them strictly in age order, up to two per cycle.

A store may only update memory once it is the oldest slot. At that point it is no longer speculative, and the block raises a release strobe with the store's address and data in the cycle it retires. A load can search the window by its own ticket. The search returns the data of the youngest older store to the same address. If that store has not yet produced its data, the search reports a stall instead. A flush input empties the whole window in one cycle.

Occupancy is tracked by a four-state machine with these states:
- EMPTY: no slots held.
- ROOM: at least two slots free and at least one held.
- LAST: exactly one slot free.
- FULL: every slot held.

After each edge the machine moves to the state that matches the new occupancy:
- fill: a claim moves EMPTY to ROOM or LAST, ROOM to LAST or FULL, and LAST to FULL.
- drain: a retirement moves the other way.
- clear: a flush returns any state to EMPTY.

The dispatch readiness outputs are decoded from this state.

Top module: `reorder_buf`

## Requirements
- R1: After reset the window is empty. Both readiness outputs are 1, no commit, release or forwarding output is active, and the tickets offered are 0 and 1.
- R2: The tickets offered are the tail index and the tail index plus one, modulo DEPTH. A claim on slot 1 is honoured only together with a claim on slot 0; slot 1 alone is ignored.
- R3: A two-slot claim is taken only when at least two slots are free; otherwise neither slot is taken. A one-slot claim needs one free slot. The output disp_ready2 is high exactly when two or more slots are free, and disp_ready is high exactly when the window is not full.
- R4: A writeback on any of NUM_WB ports clears the pending flag of the slot named by its ticket and stores its result. Several ports may write distinct tickets in the same cycle.
- R5: A writeback to a slot that is not held, or not pending, is ignored and leaves the stored result unchanged.
- R6: The oldest slot commits when it is held and not pending. The second-oldest commits only in a cycle where the oldest also commits. The commit outputs show this combinationally, and the slots retire at the next rising edge.
- R7: Commit slot 0 carries the oldest entry and slot 1 the next. Each commit slot carries a valid bit, the destination tag, the result and the is-store bit. Fields are zero when the slot is not valid.
- R8: A store in the second-oldest position never commits in that position. st_rel_valid is high exactly when a completed store commits from the oldest position, and it carries that store's address and data.
- R9: A load lookup considers held slots strictly older than the load ticket, where age is measured from the head. It picks the youngest store among them whose address equals the load address. If that store is complete, fwd_hit is 1 and fwd_data is its result. With no match, or with ld_valid low, fwd_hit, fwd_stall and fwd_data are 0.
- R10: When the youngest matching older store is still pending, fwd_stall is 1, fwd_hit is 0 and fwd_data is 0.
- R11: A flush clears every slot and resets head, tail and occupancy at the next edge. It overrides any claim and retirement in the same cycle and forces the commit and release outputs low during that cycle.
- R12: After DEPTH slots are held, with head equal to tail, the state is FULL: disp_ready is 0 and no claim is taken until a slot retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clear the whole window |
| alloc_valid | input | 2 | Claim request per dispatch slot |
| alloc_is_store | input | 2 | Per dispatch slot: instruction is a store |
| alloc_dst | input | 2*TAG_W | Destination tag per dispatch slot |
| alloc_addr | input | 2*ADDR_W | Memory address per dispatch slot |
| disp_ready | output | 1 | At least one slot free |
| disp_ready2 | output | 1 | At least two slots free |
| alloc_tkt0 | output | IDX_W | Ticket for dispatch slot 0 |
| alloc_tkt1 | output | IDX_W | Ticket for dispatch slot 1 |
| wb_valid | input | NUM_WB | Writeback strobe per port |
| wb_tkt | input | NUM_WB*IDX_W | Writeback ticket per port |
| wb_data | input | NUM_WB*DATA_W | Writeback result per port |
| cm_valid | output | 2 | Commit slot valid |
| cm_dst | output | 2*TAG_W | Commit destination tag per slot |
| cm_data | output | 2*DATA_W | Commit result per slot |
| cm_store | output | 2 | Commit slot holds a store |
| st_rel_valid | output | 1 | Head store released to memory |
| st_rel_addr | output | ADDR_W | Released store address |
| st_rel_data | output | DATA_W | Released store data |
| ld_valid | input | 1 | Load lookup request |
| ld_tkt | input | IDX_W | Ticket of the load |
| ld_addr | input | ADDR_W | Load address |
| fwd_hit | output | 1 | Forwardable store found |
| fwd_stall | output | 1 | Matching store not yet complete |
| fwd_data | output | DATA_W | Forwarded store data |

## Verification
The readiness, ticket, commit, release and forwarding outputs are combinational views of the current window. They are due in the same cycle as the inputs that shape them. A claim, writeback, retirement or flush takes effect at the next rising edge: a new ticket, a cleared pending flag or an emptied window shows up one cycle after the stimulus. The bench drives inputs at the falling edge and samples one time unit later. It compares against a reference window that it advances only at the rising edge, so each result is checked in the cycle it becomes due.

// File: rtl/reorder_buf_pkg.sv
package reorder_buf_pkg;

    // Occupancy states of the retirement window.
    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_ROOM,
        OCC_LAST,
        OCC_FULL
    } occ_state_e;

    // Advance a ring index by a small step, wrapping at depth.
    function automatic int ring_add(input int ptr, input int step, input int depth);
        int s;
        s = ptr + step;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/rob_occupancy.sv
module rob_occupancy
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       n_alloc,
    input  logic [1:0]       n_commit,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             room_one,
    output logic             room_two
);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [IDX_W-1:0] head_d, tail_d;

    // Pointer and occupancy arithmetic
    always_comb begin
        if (flush) begin
            head_d  = '0;
            tail_d  = '0;
            count_d = '0;
        end else begin
            head_d  = IDX_W'(ring_add(int'(head), int'(n_commit), DEPTH));
            tail_d  = IDX_W'(ring_add(int'(tail), int'(n_alloc), DEPTH));
            count_d = count_q + CNT_W'(n_alloc) - CNT_W'(n_commit);
        end
    end

    // Next-state selection from the occupancy after this edge
    always_comb begin
        if (count_d == '0)
            state_d = OCC_EMPTY;
        else if (count_d == CNT_W'(DEPTH))
            state_d = OCC_FULL;
        else if (count_d == CNT_W'(DEPTH - 1))
            state_d = OCC_LAST;
        else
            state_d = OCC_ROOM;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count_q <= '0;
            head    <= '0;
            tail    <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            head    <= head_d;
            tail    <= tail_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            OCC_EMPTY: begin room_one = 1'b1; room_two = 1'b1; end
            OCC_ROOM:  begin room_one = 1'b1; room_two = 1'b1; end
            OCC_LAST:  begin room_one = 1'b1; room_two = 1'b0; end
            OCC_FULL:  begin room_one = 1'b0; room_two = 1'b0; end
            default:   begin room_one = 1'b0; room_two = 1'b0; end
        endcase
    end

    // R12
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R12
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) == (count_q == CNT_W'(DEPTH)));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0 && head == '0 && tail == '0 && state_q == OCC_EMPTY));

    // R3
    pair_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_alloc == 2'd2) |-> (count_q <= CNT_W'(DEPTH - 2)));

    // R3
    single_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_alloc == 2'd1) |-> (count_q < CNT_W'(DEPTH)));

endmodule

// File: rtl/rob_fwd_search.sv
module rob_fwd_search
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]              head,
    input  logic                          ld_valid,
    input  logic [IDX_W-1:0]              ld_tkt,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [DEPTH-1:0]              ent_valid,
    input  logic [DEPTH-1:0]              ent_pend,
    input  logic [DEPTH-1:0]              ent_store,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  ent_data,
    output logic                          fwd_hit,
    output logic                          fwd_stall,
    output logic [DATA_W-1:0]             fwd_data
);

    logic             found;
    logic [IDX_W-1:0] sel;
    int               ld_age;
    int               idx;

    // Walk from oldest to youngest; the last older match wins.
    always_comb begin
        found  = 1'b0;
        sel    = '0;
        ld_age = (int'(ld_tkt) - int'(head) + DEPTH) % DEPTH;
        idx    = 0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = ring_add(int'(head), k, DEPTH);
            if (k < ld_age && ent_valid[idx] && ent_store[idx] &&
                ent_addr[idx] == ld_addr) begin
                found = 1'b1;
                sel   = IDX_W'(idx);
            end
        end
    end

    always_comb begin
        fwd_hit   = ld_valid && found && !ent_pend[sel];
        fwd_stall = ld_valid && found && ent_pend[sel];
        fwd_data  = fwd_hit ? ent_data[sel] : '0;
    end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
    import reorder_buf_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int NUM_WB = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [1:0]                 alloc_valid,
    input  logic [1:0]                 alloc_is_store,
    input  logic [2*TAG_W-1:0]         alloc_dst,
    input  logic [2*ADDR_W-1:0]        alloc_addr,
    output logic                       disp_ready,
    output logic                       disp_ready2,
    output logic [IDX_W-1:0]           alloc_tkt0,
    output logic [IDX_W-1:0]           alloc_tkt1,
    input  logic [NUM_WB-1:0]          wb_valid,
    input  logic [NUM_WB*IDX_W-1:0]    wb_tkt,
    input  logic [NUM_WB*DATA_W-1:0]   wb_data,
    output logic [1:0]                 cm_valid,
    output logic [2*TAG_W-1:0]         cm_dst,
    output logic [2*DATA_W-1:0]        cm_data,
    output logic [1:0]                 cm_store,
    output logic                       st_rel_valid,
    output logic [ADDR_W-1:0]          st_rel_addr,
    output logic [DATA_W-1:0]          st_rel_data,
    input  logic                       ld_valid,
    input  logic [IDX_W-1:0]           ld_tkt,
    input  logic [ADDR_W-1:0]          ld_addr,
    output logic                       fwd_hit,
    output logic                       fwd_stall,
    output logic [DATA_W-1:0]          fwd_data
);

    // Slot storage
    logic [DEPTH-1:0]             ent_valid;
    logic [DEPTH-1:0]             ent_pend;
    logic [DEPTH-1:0]             ent_store;
    logic [DEPTH-1:0][TAG_W-1:0]  ent_dst;
    logic [DEPTH-1:0][DATA_W-1:0] ent_data;
    logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;

    logic [IDX_W-1:0] head, tail, head1;
    logic             room_one, room_two;
    logic [1:0]       n_alloc, n_commit;
    logic             take0, take1;
    logic [NUM_WB-1:0] wb_hit;

    rob_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .n_alloc  (n_alloc),
        .n_commit (n_commit),
        .head     (head),
        .tail     (tail),
        .room_one (room_one),
        .room_two (room_two)
    );

    assign head1       = IDX_W'(ring_add(int'(head), 1, DEPTH));
    assign alloc_tkt0  = tail;
    assign alloc_tkt1  = IDX_W'(ring_add(int'(tail), 1, DEPTH));
    assign disp_ready  = room_one;
    assign disp_ready2 = room_two;

    // Claim acceptance
    always_comb begin
        if (flush)
            n_alloc = 2'd0;
        else if (alloc_valid[0] && alloc_valid[1])
            n_alloc = room_two ? 2'd2 : 2'd0;
        else if (alloc_valid[0])
            n_alloc = room_one ? 2'd1 : 2'd0;
        else
            n_alloc = 2'd0;
    end

    // Writeback qualification per port
    for (genvar p = 0; p < NUM_WB; p++) begin : g_wb
        logic [IDX_W-1:0] t;
        assign t         = wb_tkt[p*IDX_W +: IDX_W];
        assign wb_hit[p] = wb_valid[p] && ent_valid[t] && ent_pend[t];
    end

    // Retirement selection over the two oldest slots
    always_comb begin
        take0    = !flush && ent_valid[head] && !ent_pend[head];
        take1    = take0 && ent_valid[head1] && !ent_pend[head1] && !ent_store[head1];
        n_commit = {1'b0, take0} + {1'b0, take1};
    end

    always_comb begin
        cm_valid = {take1, take0};
        cm_store = {take1 && ent_store[head1], take0 && ent_store[head]};
        cm_dst   = {take1 ? ent_dst[head1]  : {TAG_W{1'b0}},
                    take0 ? ent_dst[head]   : {TAG_W{1'b0}}};
        cm_data  = {take1 ? ent_data[head1] : {DATA_W{1'b0}},
                    take0 ? ent_data[head]  : {DATA_W{1'b0}}};
        st_rel_valid = take0 && ent_store[head];
        st_rel_addr  = st_rel_valid ? ent_addr[head] : '0;
        st_rel_data  = st_rel_valid ? ent_data[head] : '0;
    end

    // Slot update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_pend  <= '0;
            ent_store <= '0;
            ent_dst   <= '0;
            ent_data  <= '0;
            ent_addr  <= '0;
        end else if (flush) begin
            ent_valid <= '0;
        end else begin
            if (n_commit != 2'd0) ent_valid[head]  <= 1'b0;
            if (n_commit == 2'd2) ent_valid[head1] <= 1'b0;
            for (int p = 0; p < NUM_WB; p++) begin
                if (wb_hit[p]) begin
                    ent_pend[wb_tkt[p*IDX_W +: IDX_W]] <= 1'b0;
                    ent_data[wb_tkt[p*IDX_W +: IDX_W]] <= wb_data[p*DATA_W +: DATA_W];
                end
            end
            if (n_alloc != 2'd0) begin
                ent_valid[alloc_tkt0] <= 1'b1;
                ent_pend[alloc_tkt0]  <= 1'b1;
                ent_store[alloc_tkt0] <= alloc_is_store[0];
                ent_dst[alloc_tkt0]   <= alloc_dst[TAG_W-1:0];
                ent_addr[alloc_tkt0]  <= alloc_addr[ADDR_W-1:0];
            end
            if (n_alloc == 2'd2) begin
                ent_valid[alloc_tkt1] <= 1'b1;
                ent_pend[alloc_tkt1]  <= 1'b1;
                ent_store[alloc_tkt1] <= alloc_is_store[1];
                ent_dst[alloc_tkt1]   <= alloc_dst[2*TAG_W-1:TAG_W];
                ent_addr[alloc_tkt1]  <= alloc_addr[2*ADDR_W-1:ADDR_W];
            end
        end
    end

    rob_fwd_search #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fwd (
        .head      (head),
        .ld_valid  (ld_valid),
        .ld_tkt    (ld_tkt),
        .ld_addr   (ld_addr),
        .ent_valid (ent_valid),
        .ent_pend  (ent_pend),
        .ent_store (ent_store),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .fwd_hit   (fwd_hit),
        .fwd_stall (fwd_stall),
        .fwd_data  (fwd_data)
    );

    // R6
    commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid[1] |-> cm_valid[0]);

    // R8
    slot1_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid[1] |-> !cm_store[1]);

    // R10
    fwd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_hit && fwd_stall));

    // R4
    wb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_hit[0] && !flush) |=> !ent_pend[$past(wb_tkt[IDX_W-1:0])]);

    // R5
    wb_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid[0] && ent_valid[wb_tkt[IDX_W-1:0]] && !ent_pend[wb_tkt[IDX_W-1:0]] && !flush)
        |=> ent_data[$past(wb_tkt[IDX_W-1:0])] == $past(ent_data[wb_tkt[IDX_W-1:0]]));

endmodule

// File: tb/test_reorder_buf.sv
module test_reorder_buf;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int TAG_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int NUM_WB = 3;
    localparam int IDX_W  = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush;
    logic [1:0] alloc_valid, alloc_is_store;
    logic [2*TAG_W-1:0] alloc_dst;
    logic [2*ADDR_W-1:0] alloc_addr;
    logic disp_ready, disp_ready2;
    logic [IDX_W-1:0] alloc_tkt0, alloc_tkt1;
    logic [NUM_WB-1:0] wb_valid;
    logic [NUM_WB*IDX_W-1:0] wb_tkt;
    logic [NUM_WB*DATA_W-1:0] wb_data;
    logic [1:0] cm_valid, cm_store;
    logic [2*TAG_W-1:0] cm_dst;
    logic [2*DATA_W-1:0] cm_data;
    logic st_rel_valid;
    logic [ADDR_W-1:0] st_rel_addr;
    logic [DATA_W-1:0] st_rel_data;
    logic ld_valid;
    logic [IDX_W-1:0] ld_tkt;
    logic [ADDR_W-1:0] ld_addr;
    logic fwd_hit, fwd_stall;
    logic [DATA_W-1:0] fwd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    reorder_buf #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
                  .ADDR_W(ADDR_W), .NUM_WB(NUM_WB)) i_reorder_buf (.*);

    // Reference window
    bit               m_valid [DEPTH];
    bit               m_pend  [DEPTH];
    bit               m_store [DEPTH];
    bit               m_ign   [DEPTH];
    logic [TAG_W-1:0]  m_dst  [DEPTH];
    logic [DATA_W-1:0] m_data [DEPTH];
    logic [ADDR_W-1:0] m_addr [DEPTH];
    int m_head, m_tail, m_count;
    bit prev_flush;
    int n_chk, n_err;
    bit done;

    function automatic int wrap(input int v);
        return ((v % DEPTH) + DEPTH) % DEPTH;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_c0();
        return !flush && m_valid[m_head] && !m_pend[m_head];
    endfunction

    function automatic bit exp_c1();
        int h1 = wrap(m_head + 1);
        return exp_c0() && m_valid[h1] && !m_pend[h1] && !m_store[h1];
    endfunction

    task automatic check_outputs();
        int free = DEPTH - m_count;
        int h1 = wrap(m_head + 1);
        bit c0 = exp_c0();
        bit c1 = exp_c1();
        bit found = 0;
        int sel = 0;
        int ld_age;
        string rq;
        rq = (m_count == DEPTH) ? "R12" : "R3";
        chk(rq, "disp_ready", disp_ready, free >= 1);
        chk(rq, "disp_ready2", disp_ready2, free >= 2);
        rq = prev_flush ? "R11" : "R2";
        chk(rq, "alloc_tkt0", alloc_tkt0, m_tail);
        chk(rq, "alloc_tkt1", alloc_tkt1, wrap(m_tail + 1));
        rq = flush ? "R11" : "R6";
        chk(rq, "cm_valid", cm_valid, {c1, c0});
        if (c0) begin
            chk("R7", "cm_dst0", cm_dst[TAG_W-1:0], m_dst[m_head]);
            chk("R7", "cm_store0", cm_store[0], m_store[m_head]);
            chk(m_ign[m_head] ? "R5" : "R4", "cm_data0", cm_data[DATA_W-1:0], m_data[m_head]);
        end
        if (c1) begin
            chk("R7", "cm_dst1", cm_dst[2*TAG_W-1:TAG_W], m_dst[h1]);
            chk(m_ign[h1] ? "R5" : "R4", "cm_data1", cm_data[2*DATA_W-1:DATA_W], m_data[h1]);
        end
        chk("R8", "st_rel_valid", st_rel_valid, c0 && m_store[m_head]);
        if (c0 && m_store[m_head]) begin
            chk("R8", "st_rel_addr", st_rel_addr, m_addr[m_head]);
            chk("R8", "st_rel_data", st_rel_data, m_data[m_head]);
        end
        ld_age = wrap(int'(ld_tkt) - m_head);
        for (int k = 0; k < ld_age; k++) begin
            int ix = wrap(m_head + k);
            if (m_valid[ix] && m_store[ix] && m_addr[ix] == ld_addr) begin
                found = 1;
                sel = ix;
            end
        end
        chk("R9", "fwd_hit", fwd_hit, ld_valid && found && !m_pend[sel]);
        chk("R10", "fwd_stall", fwd_stall, ld_valid && found && m_pend[sel]);
        chk("R9", "fwd_data", fwd_data,
            (ld_valid && found && !m_pend[sel]) ? m_data[sel] : '0);
    endtask

    task automatic advance_model();
        int na = 0;
        int nc = exp_c0() + exp_c1();
        int free = DEPTH - m_count;
        if (alloc_valid == 2'b11) na = (free >= 2) ? 2 : 0;
        else if (alloc_valid[0]) na = (free >= 1) ? 1 : 0;
        prev_flush = flush;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
            m_head = 0; m_tail = 0; m_count = 0;
            return;
        end
        for (int i = 0; i < nc; i++) m_valid[wrap(m_head + i)] = 0;
        for (int p = 0; p < NUM_WB; p++) begin
            int t = int'(wb_tkt[p*IDX_W +: IDX_W]);
            if (wb_valid[p] && m_valid[t]) begin
                if (m_pend[t]) begin
                    m_pend[t] = 0;
                    m_data[t] = wb_data[p*DATA_W +: DATA_W];
                end else m_ign[t] = 1;
            end
        end
        for (int i = 0; i < na; i++) begin
            int t = wrap(m_tail + i);
            m_valid[t] = 1; m_pend[t] = 1; m_ign[t] = 0;
            m_store[t] = alloc_is_store[i];
            m_dst[t]   = alloc_dst[i*TAG_W +: TAG_W];
            m_addr[t]  = alloc_addr[i*ADDR_W +: ADDR_W];
        end
        m_head = wrap(m_head + nc);
        m_tail = wrap(m_tail + na);
        m_count = m_count + na - nc;
    endtask

    task automatic step();
        #1;
        check_outputs();
        advance_model();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        flush = 0; alloc_valid = '0; alloc_is_store = '0; alloc_dst = '0;
        alloc_addr = '0; wb_valid = '0; wb_tkt = '0; wb_data = '0;
        ld_valid = 0; ld_tkt = '0; ld_addr = '0;
    endtask

    // mode 0: fill, 1: drain, 2: mixed, 3: flush-heavy
    task automatic gen(input int mode);
        idle_inputs();
        if (mode != 1) alloc_valid = (mode == 0) ? 2'b11 : 2'($urandom % 4);
        else if ($urandom % 6 == 0) alloc_valid = 2'b01;
        for (int i = 0; i < 2; i++) begin
            alloc_is_store[i] = ($urandom % 10) < 4;
            alloc_dst[i*TAG_W +: TAG_W] = TAG_W'($urandom);
            alloc_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(($urandom % 4) * 4);
        end
        if (mode != 0) begin
            for (int p = 0; p < NUM_WB; p++) begin
                int t;
                bit dup = 0;
                if (($urandom % 4) == 0) t = $urandom % DEPTH;
                else t = wrap(m_head + int'($urandom % (m_count + 1)));
                for (int q = 0; q < p; q++)
                    if (wb_valid[q] && int'(wb_tkt[q*IDX_W +: IDX_W]) == t) dup = 1;
                wb_valid[p] = !dup && (($urandom % 3) != 0);
                wb_tkt[p*IDX_W +: IDX_W] = IDX_W'(t);
                wb_data[p*DATA_W +: DATA_W] = $urandom;
            end
        end
        ld_valid = ($urandom % 3) != 0;
        ld_tkt = IDX_W'(wrap(m_head + int'($urandom % (m_count + 1))));
        ld_addr = ADDR_W'(($urandom % 4) * 4);
        flush = (mode == 3) ? (($urandom % 8) == 0) : (mode == 2 && ($urandom % 200) == 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7715));
        idle_inputs();
        m_head = 0; m_tail = 0; m_count = 0; prev_flush = 0;
        for (int i = 0; i < DEPTH; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "disp_ready", disp_ready, 1);
        chk("R1", "disp_ready2", disp_ready2, 1);
        chk("R1", "cm_valid", cm_valid, 0);
        chk("R1", "st_rel_valid", st_rel_valid, 0);
        chk("R1", "tickets", {alloc_tkt1, alloc_tkt0}, {IDX_W'(1), IDX_W'(0)});
        // R2 slot 1 alone is ignored
        alloc_valid = 2'b10;
        step();
        #1 chk("R2", "tkt0 after lone slot1", alloc_tkt0, 0);
        // single claim, then fill to FULL (R12) and hold there
        idle_inputs(); alloc_valid = 2'b01; alloc_is_store = 2'b01;
        step();
        for (int i = 0; i < 6; i++) begin gen(0); step(); end
        idle_inputs(); alloc_valid = 2'b01; step();
        #1 chk("R12", "full disp_ready", disp_ready, 0);
        for (int i = 0; i < 40; i++) begin gen(1); step(); end
        for (int i = 0; i < 3000; i++) begin gen(2); step(); end
        for (int i = 0; i < 400; i++) begin gen(3); step(); end
        // R11 flush while claiming
        gen(2); flush = 1; alloc_valid = 2'b11; step();
        for (int i = 0; i < 300; i++) begin gen(i % 3); step(); end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule